// File: doc/BRIEF.md
# Spindle Start/Stop Brake Sequencer

This block sequences a disc spindle motor through spin-up, steady running and shutdown. It owns the spindle's two-wire PWM drive (a plus wire that accelerates and a minus wire that decelerates). A separate constant-linear-velocity (CLV) servo loop supplies the PWM during steady running. The sequencer does not contain that loop. It raises an enable for it and passes the loop's PWM pair through while the loop is in control.

A rising edge on the start request begins a kick: full forward drive for a programmable number of time-base ticks. When the kick ends, control passes to the servo. A falling edge on the start request begins shutdown, and the brake-mode select chooses how it runs. In the automatic mode, the block measures the time t until the rotation detector reports two thirds of a revolution. It then keeps braking until 3t has elapsed in total, and t is capped. In the manual mode, the brake is applied only while a brake input is held. A new start request during any brake phase abandons the brake and starts a fresh kick.

Top module: `spindle_seq`

## Requirements
- R1: While reset is low and right after it, drive_o is 0 (off), clv_en_o is 0, rot_flag_o is 0, and both PWM outputs are 0.
- R2: drive_o encodes 0=off, 1=kick, 2=CLV, 3=brake. One clock after a 0-to-1 change of start_i, drive_o is 1, and pwm_plus_o=1 with pwm_minus_o=0 for as long as the kick lasts.
- R3: A kick lasts for kick_len_i+1 counted ticks, so a value of 0 gives a one-tick kick. One clock after the last counted tick, drive_o becomes 2.
- R4: While kick_hold_i is 1, ticks are not counted and the kick goes on.
- R5: In CLV, clv_en_o is 1 and pwm_plus_o/pwm_minus_o follow pwm_plus_i/pwm_minus_i. In every other state, clv_en_o is 0.
- R6: When start_i falls with brk_manual_i=0, drive_o is 3 (pwm_minus_o=1, pwm_plus_o=0) while ticks t are counted until a rot_pulse_i arrives. Braking then continues for 2t more ticks, and drive_o then becomes 0.
- R7: If no rotation pulse arrives, t saturates at T_MAX_TICKS. The brake then continues for 2*T_MAX_TICKS more ticks and drive_o becomes 0.
- R8: rot_flag_o is set one clock after a rotation pulse that ends an automatic-brake measurement. It is cleared on a start rising edge. Rotation pulses at any other time leave it unchanged.
- R9: When start_i falls with brk_manual_i=1, drive_o is 3 while brake_i is 1 and 0 while brake_i is 0, until the next start.
- R10: A 0-to-1 change of start_i during any brake phase (measuring, tail or manual) gives drive_o=1 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base tick strobe, one cycle wide |
| start_i | input | 1 | Start (1) / stop (0) request |
| brk_manual_i | input | 1 | Brake mode: 0 automatic, 1 manual |
| brake_i | input | 1 | Manual brake request |
| kick_hold_i | input | 1 | Freezes the kick timer when 1 |
| kick_len_i | input | KICK_W | Kick length minus one, in ticks |
| rot_pulse_i | input | 1 | Two-thirds-rotation detect pulse |
| pwm_plus_i | input | 1 | Servo loop forward PWM |
| pwm_minus_i | input | 1 | Servo loop reverse PWM |
| drive_o | output | 2 | Drive state: 0 off, 1 kick, 2 CLV, 3 brake |
| clv_en_o | output | 1 | Servo loop enable |
| rot_flag_o | output | 1 | Rotation-detected monitor flag |
| pwm_plus_o | output | 1 | Spindle forward drive |
| pwm_minus_o | output | 1 | Spindle reverse drive |

## Verification
The bench builds the block with T_MAX_TICKS=20 and a tick every third clock. At those values, the saturated 3*T_MAX brake, about 180 clocks, fits inside a short run, so R7 is reached alongside a measured brake of a few ticks. The kick width stays at its default of 8 bits. This lets the kick lengths 0 and 3 be exercised with the same encoding the design uses. A behavioural model tracks the expected drive state every clock.

// File: rtl/spindle_pkg.sv
package spindle_pkg;
  typedef enum logic [1:0] {
    DRV_OFF   = 2'd0,
    DRV_KICK  = 2'd1,
    DRV_CLV   = 2'd2,
    DRV_BRAKE = 2'd3
  } drive_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KICK,
    ST_CLV,
    ST_MEAS,
    ST_TAIL,
    ST_MAN
  } seq_state_e;
endpackage

// File: rtl/spindle_edge.sv
module spindle_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
  assign fall_o = ~sig_i & sig_q;
endmodule

// File: rtl/spindle_kick_tmr.sv
module spindle_kick_tmr #(
  parameter int KICK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [KICK_W-1:0] len_i,
  input  logic              dec_i,
  output logic              zero_o
);
  logic [KICK_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (load_i)                    cnt_q <= len_i;
    else if (dec_i && (cnt_q != '0))    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/spindle_brk_tmr.sv
module spindle_brk_tmr #(
  parameter int T_MAX_TICKS = 8800
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  input  logic capture_i,
  input  logic dec_i,
  output logic at_cap_o,
  output logic t_zero_o,
  output logic rem_zero_o
);
  localparam int TW = $clog2(T_MAX_TICKS + 1);
  localparam int RW = TW + 1;
  localparam logic [TW-1:0] T_CAP = TW'(T_MAX_TICKS);

  logic [TW-1:0] t_q;
  logic [RW-1:0] rem_q;

  // measured interval, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     t_q <= '0;
    else if (clr_i)                  t_q <= '0;
    else if (inc_i && (t_q != T_CAP)) t_q <= t_q + 1'b1;
  end

  // remaining tail = 2t
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        rem_q <= '0;
    else if (capture_i)                 rem_q <= {t_q, 1'b0};
    else if (dec_i && (rem_q != '0))    rem_q <= rem_q - 1'b1;
  end

  assign at_cap_o   = (t_q == T_CAP);
  assign t_zero_o   = (t_q == '0);
  assign rem_zero_o = (rem_q == '0);
endmodule

// File: rtl/spindle_drive_mux.sv
module spindle_drive_mux
  import spindle_pkg::*;
(
  input  seq_state_e state_i,
  input  logic       brake_i,
  input  logic       pwm_plus_i,
  input  logic       pwm_minus_i,
  output drive_e     drive_o,
  output logic       clv_en_o,
  output logic       pwm_plus_o,
  output logic       pwm_minus_o
);
  always_comb begin
    case (state_i)
      ST_KICK:         drive_o = DRV_KICK;
      ST_CLV:          drive_o = DRV_CLV;
      ST_MEAS, ST_TAIL: drive_o = DRV_BRAKE;
      ST_MAN:          drive_o = brake_i ? DRV_BRAKE : DRV_OFF;
      default:         drive_o = DRV_OFF;
    endcase
  end

  always_comb begin
    case (drive_o)
      DRV_KICK:  begin pwm_plus_o = 1'b1;       pwm_minus_o = 1'b0;        end
      DRV_CLV:   begin pwm_plus_o = pwm_plus_i; pwm_minus_o = pwm_minus_i; end
      DRV_BRAKE: begin pwm_plus_o = 1'b0;       pwm_minus_o = 1'b1;        end
      default:   begin pwm_plus_o = 1'b0;       pwm_minus_o = 1'b0;        end
    endcase
  end

  assign clv_en_o = (state_i == ST_CLV);
endmodule

// File: rtl/spindle_seq.sv
module spindle_seq
  import spindle_pkg::*;
#(
  parameter int KICK_W      = 8,
  parameter int T_MAX_TICKS = 8800
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              brk_manual_i,
  input  logic              brake_i,
  input  logic              kick_hold_i,
  input  logic [KICK_W-1:0] kick_len_i,
  input  logic              rot_pulse_i,
  input  logic              pwm_plus_i,
  input  logic              pwm_minus_i,
  output logic [1:0]        drive_o,
  output logic              clv_en_o,
  output logic              rot_flag_o,
  output logic              pwm_plus_o,
  output logic              pwm_minus_o
);
  seq_state_e st_q, st_d;
  drive_e     drive;
  logic start_rise, start_fall;
  logic kick_load, kick_dec, kick_zero;
  logic meas_clr, meas_inc, tail_cap, tail_dec;
  logic at_cap, t_zero, rem_zero;
  logic flag_q;

  spindle_edge u_start_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (start_i),
    .rise_o (start_rise),
    .fall_o (start_fall)
  );

  spindle_kick_tmr #(.KICK_W(KICK_W)) u_kick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (kick_load),
    .len_i  (kick_len_i),
    .dec_i  (kick_dec),
    .zero_o (kick_zero)
  );

  spindle_brk_tmr #(.T_MAX_TICKS(T_MAX_TICKS)) u_brk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (meas_clr),
    .inc_i      (meas_inc),
    .capture_i  (tail_cap),
    .dec_i      (tail_dec),
    .at_cap_o   (at_cap),
    .t_zero_o   (t_zero),
    .rem_zero_o (rem_zero)
  );

  assign kick_dec = (st_q == ST_KICK) && tick_i && !kick_hold_i;
  assign meas_inc = (st_q == ST_MEAS) && tick_i;
  assign tail_dec = (st_q == ST_TAIL) && tick_i;

  always_comb begin
    st_d      = st_q;
    kick_load = 1'b0;
    meas_clr  = 1'b0;
    tail_cap  = 1'b0;
    if (start_rise) begin
      // restart wins over every phase, brakes included
      st_d      = ST_KICK;
      kick_load = 1'b1;
    end else if (start_fall && (st_q == ST_KICK || st_q == ST_CLV)) begin
      if (brk_manual_i) begin
        st_d = ST_MAN;
      end else begin
        st_d     = ST_MEAS;
        meas_clr = 1'b1;
      end
    end else begin
      case (st_q)
        ST_KICK: if (kick_dec && kick_zero) st_d = ST_CLV;
        ST_MEAS: begin
          if (rot_pulse_i) begin
            tail_cap = 1'b1;
            st_d     = t_zero ? ST_IDLE : ST_TAIL;
          end else if (at_cap) begin
            tail_cap = 1'b1;
            st_d     = ST_TAIL;
          end
        end
        ST_TAIL: if (rem_zero) st_d = ST_IDLE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               flag_q <= 1'b0;
    else if (start_rise)                       flag_q <= 1'b0;
    else if (st_q == ST_MEAS && rot_pulse_i)   flag_q <= 1'b1;
  end

  spindle_drive_mux u_mux (
    .state_i     (st_q),
    .brake_i     (brake_i),
    .pwm_plus_i  (pwm_plus_i),
    .pwm_minus_i (pwm_minus_i),
    .drive_o     (drive),
    .clv_en_o    (clv_en_o),
    .pwm_plus_o  (pwm_plus_o),
    .pwm_minus_o (pwm_minus_o)
  );

  assign drive_o    = drive;
  assign rot_flag_o = flag_q;
endmodule

// File: rtl/spindle_seq_chk.sv
module spindle_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       rot_pulse_i,
  input logic [1:0] drive_o,
  input logic       clv_en_o,
  input logic       rot_flag_o,
  input logic       pwm_plus_o,
  input logic       pwm_minus_o
);
  assert_kick_on_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_i) |=> drive_o == 2'd1);

  assert_kick_polarity_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o == 2'd1 |-> (pwm_plus_o && !pwm_minus_o));

  assert_clv_from_kick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o == 2'd2 && $past(drive_o) != 2'd2) |-> $past(drive_o) == 2'd1);

  assert_clv_enable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clv_en_o == (drive_o == 2'd2));

  assert_brake_polarity_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o == 2'd3 |-> (pwm_minus_o && !pwm_plus_o));

  assert_flag_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rot_flag_o) |-> $past(rot_pulse_i));

  assert_off_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o == 2'd0 |-> (!pwm_plus_o && !pwm_minus_o && !clv_en_o));
endmodule

bind spindle_seq spindle_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .rot_pulse_i (rot_pulse_i),
  .drive_o     (drive_o),
  .clv_en_o    (clv_en_o),
  .rot_flag_o  (rot_flag_o),
  .pwm_plus_o  (pwm_plus_o),
  .pwm_minus_o (pwm_minus_o)
);

// File: tb/spindle_seq_test.sv
`timescale 1ns/100ps
module spindle_seq_test;
  localparam int KW = 8;
  localparam int TMAX = 20;
  localparam int TICK_DIV = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, start = 1'b0, manual = 1'b0, brake = 1'b0, hold = 1'b0;
  logic [KW-1:0] klen = '0;
  logic rot = 1'b0, p_in = 1'b0, m_in = 1'b0;
  logic [1:0] drive;
  logic clv_en, rflag, p_out, m_out;

  int n_chk = 0, n_fail = 0, tcnt = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  spindle_seq #(.KICK_W(KW), .T_MAX_TICKS(TMAX)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .start_i(start),
    .brk_manual_i(manual), .brake_i(brake), .kick_hold_i(hold),
    .kick_len_i(klen), .rot_pulse_i(rot), .pwm_plus_i(p_in),
    .pwm_minus_i(m_in), .drive_o(drive), .clv_en_o(clv_en),
    .rot_flag_o(rflag), .pwm_plus_o(p_out), .pwm_minus_o(m_out)
  );

  // behavioural model: 0 idle,1 kick,2 clv,3 measure,4 tail,5 manual
  int m_st = 0, m_kc = 0, m_t = 0, m_rem = 0;
  bit m_flag = 0, m_sq = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_kc = 0; m_t = 0; m_rem = 0; m_flag = 0; m_sq = 0;
    end else begin
      bit rise, fall;
      rise = start && !m_sq;
      fall = !start && m_sq;
      m_sq = start;
      if (rise) begin
        m_st = 1; m_kc = klen; m_flag = 0;
      end else if (fall && (m_st == 1 || m_st == 2)) begin
        if (manual) m_st = 5;
        else begin m_st = 3; m_t = 0; end
      end else begin
        case (m_st)
          1: if (tick && !hold) begin
               if (m_kc == 0) m_st = 2; else m_kc--;
             end
          3: if (rot) begin
               m_flag = 1;
               if (m_t == 0) m_st = 0; else begin m_rem = 2 * m_t; m_st = 4; end
             end else if (m_t == TMAX) begin
               m_rem = 2 * TMAX; m_st = 4;
             end else if (tick) m_t++;
          4: if (m_rem == 0) m_st = 0; else if (tick) m_rem--;
          default: ;
        endcase
      end
    end
  end

  function automatic int exp_drive();
    case (m_st)
      1: return 1;
      2: return 2;
      3, 4: return 3;
      5: return brake ? 3 : 0;
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int ed, ep, em;
      ed = exp_drive();
      ep = (ed == 1) ? 1 : (ed == 2) ? int'(p_in) : 0;
      em = (ed == 3) ? 1 : (ed == 2) ? int'(m_in) : 0;
      n_chk++;
      if (drive !== 2'(ed) || clv_en !== (ed == 2) || rflag !== m_flag ||
          p_out !== 1'(ep) || m_out !== 1'(em)) begin
        n_fail++;
        $display("FAIL %s model: drive=%0d clv=%0b flag=%0b p=%0b m=%0b expected drive=%0d clv=%0b flag=%0b p=%0d m=%0d",
                 cur_req, drive, clv_en, rflag, p_out, m_out, ed, (ed == 2), m_flag, ep, em);
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      tick = (tcnt == TICK_DIV - 1);
      tcnt = (tcnt + 1) % TICK_DIV;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    cyc(4);
    chk("R1", drive, 0); chk("R1", clv_en, 0); chk("R1", rflag, 0);
    chk("R1", {p_out, m_out}, 0);
    rst_n = 1'b1; cyc(2);
    chk("R1", drive, 0);

    // R2/R3 kick of 4 ticks then CLV
    cur_req = "R2"; klen = 8'd3; start = 1'b1; cyc(1);
    chk("R2", drive, 1); chk("R2", {p_out, m_out}, 2'b10);
    cur_req = "R3"; cyc(8); chk("R3", drive, 1);
    cyc(8); chk("R3", drive, 2); chk("R3", clv_en, 1);

    // R5 pass-through
    cur_req = "R5";
    for (int i = 0; i < 6; i++) begin
      p_in = i[0]; m_in = i[1]; cyc(1);
      chk("R5", {p_out, m_out}, {p_in, m_in});
    end

    // R6/R8 measured brake
    cur_req = "R6"; start = 1'b0; cyc(15);
    chk("R6", drive, 3); chk("R6", {p_out, m_out}, 2'b01);
    rot = 1'b1; cyc(1); rot = 1'b0;
    chk("R8", rflag, 1); chk("R6", drive, 3);
    cyc(60); chk("R6", drive, 0);
    cur_req = "R8"; rot = 1'b1; cyc(1); rot = 1'b0; cyc(1);
    chk("R8", drive, 0); chk("R8", rflag, 1);

    // R3 one-tick kick for length 0
    cur_req = "R3"; klen = 8'd0; start = 1'b1; cyc(1);
    chk("R3", drive, 1); chk("R8", rflag, 0);
    cyc(4); chk("R3", drive, 2);

    // R10 restart during measure, R4 hold
    cur_req = "R10"; start = 1'b0; cyc(4); chk("R10", drive, 3);
    klen = 8'd2; hold = 1'b1; start = 1'b1; cyc(1); chk("R10", drive, 1);
    cur_req = "R4"; cyc(30); chk("R4", drive, 1);
    hold = 1'b0; cyc(12); chk("R4", drive, 2);

    // R7 saturated measurement
    cur_req = "R7"; start = 1'b0; cyc(150); chk("R7", drive, 3);
    cyc(60); chk("R7", drive, 0); chk("R7", rflag, 0);

    // R10 restart during tail
    cur_req = "R10"; klen = 8'd1; start = 1'b1; cyc(12); chk("R10", drive, 2);
    start = 1'b0; cyc(9); rot = 1'b1; cyc(1); rot = 1'b0; cyc(4);
    chk("R10", drive, 3); start = 1'b1; cyc(1); chk("R10", drive, 1);
    cyc(10); chk("R10", drive, 2);

    // R9 manual brake
    cur_req = "R9"; manual = 1'b1; brake = 1'b0; start = 1'b0; cyc(2);
    chk("R9", drive, 0);
    brake = 1'b1; cyc(1); chk("R9", drive, 3); chk("R9", {p_out, m_out}, 2'b01);
    cyc(20); chk("R9", drive, 3);
    brake = 1'b0; cyc(1); chk("R9", drive, 0);
    cur_req = "R8"; rot = 1'b1; cyc(1); rot = 1'b0; cyc(1); chk("R8", rflag, 0);
    cur_req = "R10"; brake = 1'b1; cyc(1); start = 1'b1; cyc(1); chk("R10", drive, 1);
    cyc(10); chk("R10", drive, 2);
    cyc(3);
    finish_run();
  end
endmodule